// File: doc/BRIEF.md
# Banked Level Interrupt Mask Controller

This block gathers level-sensitive interrupt sources, arranged as 32-bit words, and routes them to several parent interrupt requests, one per CPU bank. All banks see the same source levels. Each bank keeps its own mask bits and raises its own request whenever any source that is high is also unmasked in that bank. Software decides which bank services a source by unmasking it in that bank only.

Access is through a simple 32-bit bus with a bank select, a byte address, a write strobe and write data. Read data is combinational and has no side effect. Inside a bank the registers are grouped by kind: every live-level word comes first, then every mask readback word, then every mask-set word, then every mask-clear word. Masking is done with write-one-to-set and write-one-to-clear words, so software never needs a read-modify-write.

Top module: `banked_irq_mask_ctrl`

## Requirements
- R1: After a synchronous reset every mask bit of every bank is 1 and every request output is 0.
- R2: The byte offset of a register is (kind * N_WORDS + word) * 4, with kind 0 = live level, 1 = mask readback, 2 = mask set, 3 = mask clear. Address bits [1:0] are ignored.
- R3: A live-level read returns the current source levels of that word (bit i = source word*32+i), with no latching. Writes to it have no effect.
- R4: A mask-set write sets the mask bits where the data is 1 and leaves the bits where it is 0. With no write, mask bits hold.
- R5: A mask-clear write clears the mask bits where the data is 1 and leaves the bits where it is 0.
- R6: A mask readback read returns the bank's mask bits for that word. Writes to it have no effect. Reads of the mask-set and mask-clear words return 0.
- R7: Request bit b is a register that equals, one clock after the inputs, the OR over all words of (source level AND NOT bank b mask). It falls one clock after the last such bit goes away.
- R8: A write changes only the mask of the bank named by the bank select.
- R9: Byte offsets at or above N_WORDS * 16, and bank selects at or above N_BANKS, read as 0 and writes to them change no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | N_WORDS*32 | Live level of every source, bit n = source n |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_bank | input | BANK_IDX_W | Bank addressed by the access |
| bus_addr | input | ADDR_W | Byte offset inside the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_bank and bus_addr |
| irq_req | output | N_BANKS | Registered request per bank |

## Verification
The assertions take for granted that source levels and bus inputs are steady around the rising edge and that at most one write arrives per cycle, so a mask-set and a mask-clear for the same word never meet. They also assume no write is issued while reset is low, so the first cycle after reset sees all masks set. The stimulus changes sources and bus signals only at the falling edge and issues writes one at a time through a single task, which keeps it within these limits.

// File: rtl/banked_irq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the banked level interrupt mask controller.
// Assumes sources are grouped in 32-bit words.
package banked_irq_pkg;
    localparam int SRC_PER_WORD = 32;

    // Register kind; the numeric value is the group index in the address map.
    typedef enum logic [1:0] {
        KIND_LEVEL  = 2'd0,
        KIND_MSTAT  = 2'd1,
        KIND_MSET   = 2'd2,
        KIND_MCLR   = 2'd3
    } reg_kind_e;

    typedef logic [SRC_PER_WORD-1:0] word_t;
endpackage

// File: rtl/birq_addr_decode.sv
`timescale 1ns/1ps
// Splits a byte offset into register kind and word index.
// Assumes the map groups all words of one kind together; bits [1:0] ignored.
module birq_addr_decode #(
    parameter int N_WORDS = 2,
    parameter int ADDR_W  = 8,
    localparam int WORD_IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic [ADDR_W-1:0]          addr,
    output banked_irq_pkg::reg_kind_e  kind,
    output logic [WORD_IDX_W-1:0]      word,
    output logic                       hit
);
    localparam int SPAN_BYTES = N_WORDS * 16;

    int unsigned idx;
    logic        unused_lo;

    assign unused_lo = ^addr[1:0];

    // Purpose: derive word index, kind and range hit from the offset.
    always_comb begin
        idx  = 32'(addr[ADDR_W-1:2]);
        hit  = (32'(addr) < SPAN_BYTES);
        kind = banked_irq_pkg::reg_kind_e'(2'(idx / 32'(N_WORDS)));
        word = WORD_IDX_W'(idx % 32'(N_WORDS));
    end
endmodule

// File: rtl/birq_mask_bank.sv
`timescale 1ns/1ps
// One bank: mask storage for every word plus the registered request.
// Assumes at most one set or clear per cycle; if both hit a bit, set wins.
module birq_mask_bank #(
    parameter int N_WORDS = 2,
    localparam int WORD_IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int SRC_W = N_WORDS * banked_irq_pkg::SRC_PER_WORD
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SRC_W-1:0]       src_lvl,
    input  logic                   set_en,
    input  logic                   clr_en,
    input  logic [WORD_IDX_W-1:0]  word_sel,
    input  banked_irq_pkg::word_t  bits,
    output logic [SRC_W-1:0]       mask_o,
    output logic                   irq_o
);
    localparam int WB = banked_irq_pkg::SRC_PER_WORD;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        banked_irq_pkg::word_t mask_q;
        banked_irq_pkg::word_t set_bits;
        banked_irq_pkg::word_t clr_bits;

        // Purpose: select the write data only for the addressed word.
        always_comb begin
            set_bits = (set_en && (32'(word_sel) == w)) ? bits : '0;
            clr_bits = (clr_en && (32'(word_sel) == w)) ? bits : '0;
        end

        // Purpose: hold mask bits; reset masks every source.
        always_ff @(posedge clk) begin
            if (!rst_n) mask_q <= '1;
            else        mask_q <= (mask_q & ~clr_bits) | set_bits;
        end

        assign mask_o[w*WB +: WB] = mask_q;
    end

    // Purpose: register the OR of all unmasked pending sources.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(src_lvl & ~mask_o);
    end
endmodule

// File: rtl/birq_read_mux.sv
`timescale 1ns/1ps
// Read path for the addressed bank; set and clear words read as zero.
// Assumes the caller has already selected that bank's mask vector.
module birq_read_mux #(
    parameter int N_WORDS = 2,
    localparam int WORD_IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int SRC_W = N_WORDS * banked_irq_pkg::SRC_PER_WORD
) (
    input  banked_irq_pkg::reg_kind_e  kind,
    input  logic [WORD_IDX_W-1:0]      word,
    input  logic                       valid,
    input  logic [SRC_W-1:0]           src_lvl,
    input  logic [SRC_W-1:0]           bank_mask,
    output banked_irq_pkg::word_t      rdata
);
    localparam int WB = banked_irq_pkg::SRC_PER_WORD;

    // Purpose: pick the live level or mask word, zero otherwise.
    always_comb begin
        rdata = '0;
        if (valid) begin
            case (kind)
                banked_irq_pkg::KIND_LEVEL: rdata = src_lvl[32'(word)*WB +: WB];
                banked_irq_pkg::KIND_MSTAT: rdata = bank_mask[32'(word)*WB +: WB];
                default:                    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/banked_irq_mask_ctrl.sv
`timescale 1ns/1ps
// Top: per-CPU banks of mask bits over shared level sources, one request
// per bank. Assumes single-cycle writes and side-effect free reads.
module banked_irq_mask_ctrl #(
    parameter int N_WORDS = 2,
    parameter int N_BANKS = 2,
    parameter int ADDR_W  = 8,
    localparam int BANK_IDX_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
    localparam int SRC_W = N_WORDS * banked_irq_pkg::SRC_PER_WORD
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SRC_W-1:0]       src_lvl,
    input  logic                   bus_wr,
    input  logic [BANK_IDX_W-1:0]  bus_bank,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic [N_BANKS-1:0]     irq_req
);
    localparam int WORD_IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    banked_irq_pkg::reg_kind_e  kind;
    logic [WORD_IDX_W-1:0]      word;
    logic                       hit;
    logic                       bank_ok;
    logic [BANK_IDX_W-1:0]      bank_idx;
    logic [N_BANKS*SRC_W-1:0]   mask_all;
    logic [SRC_W-1:0]           sel_mask;

    birq_addr_decode #(.N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .kind (kind),
        .word (word),
        .hit  (hit)
    );

    // Purpose: qualify the bank select and pick that bank's mask.
    always_comb begin
        bank_ok  = (32'(bus_bank) < N_BANKS);
        bank_idx = bank_ok ? bus_bank : '0;
        sel_mask = mask_all[32'(bank_idx)*SRC_W +: SRC_W];
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = bus_wr && hit && bank_ok && (32'(bus_bank) == b);

        birq_mask_bank #(.N_WORDS(N_WORDS)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_lvl  (src_lvl),
            .set_en   (sel && (kind == banked_irq_pkg::KIND_MSET)),
            .clr_en   (sel && (kind == banked_irq_pkg::KIND_MCLR)),
            .word_sel (word),
            .bits     (bus_wdata),
            .mask_o   (mask_all[b*SRC_W +: SRC_W]),
            .irq_o    (irq_req[b])
        );
    end

    birq_read_mux #(.N_WORDS(N_WORDS)) rd_i (
        .kind      (kind),
        .word      (word),
        .valid     (hit && bank_ok),
        .src_lvl   (src_lvl),
        .bank_mask (sel_mask),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/birq_checker.sv
`timescale 1ns/1ps
// Assertion checker for banked_irq_mask_ctrl, attached by bind below.
// Assumes one write per cycle and no write while reset is low.
module birq_checker #(
    parameter int N_WORDS = 2,
    parameter int N_BANKS = 2,
    parameter int ADDR_W  = 8,
    localparam int BANK_IDX_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
    localparam int SRC_W = N_WORDS * 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [SRC_W-1:0]       src_lvl,
    input logic                   bus_wr,
    input logic [BANK_IDX_W-1:0]  bus_bank,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [31:0]            bus_wdata,
    input logic [N_BANKS-1:0]     irq_req,
    input logic [N_BANKS*SRC_W-1:0] mask_all
);
    int unsigned  c_idx;
    int unsigned  c_kind;
    int unsigned  c_word;
    logic         c_eff;
    logic         rst_was_low_q;
    logic         wr_q;
    int unsigned  kind_q, word_q, bank_q;
    logic [31:0]  data_q;
    logic [31:0]  cur_word;
    logic [N_BANKS-1:0] pend_q;

    // Purpose: independent decode of the current write.
    always_comb begin
        c_idx  = 32'(bus_addr) >> 2;
        c_kind = c_idx / N_WORDS;
        c_word = c_idx % N_WORDS;
        c_eff  = (32'(bus_addr) < N_WORDS*16) && (32'(bus_bank) < N_BANKS)
                 && (c_kind >= 2);
    end

    // Purpose: remember last write, reset state and expected pending OR.
    always_ff @(posedge clk) begin
        rst_was_low_q <= !rst_n;
        if (!rst_n) begin
            wr_q <= 1'b0; kind_q <= 0; word_q <= 0; bank_q <= 0; data_q <= '0;
            pend_q <= '0;
        end else begin
            wr_q   <= bus_wr && c_eff;
            kind_q <= c_kind;
            word_q <= c_word;
            bank_q <= 32'(bus_bank);
            data_q <= bus_wdata;
            for (int b = 0; b < N_BANKS; b++)
                pend_q[b] <= |(src_lvl & ~mask_all[b*SRC_W +: SRC_W]);
        end
    end

    assign cur_word = mask_all[(bank_q % N_BANKS)*SRC_W + (word_q % N_WORDS)*32 +: 32];

    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_was_low_q |-> ((&mask_all) && (irq_req == '0)));                 // R1
    AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q && kind_q == 2) |-> ((cur_word & data_q) == data_q));          // R4
    AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q && kind_q == 3) |-> ((cur_word & data_q) == 32'd0));           // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(mask_all));                                      // R4
    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !c_eff) |=> $stable(mask_all));                           // R9
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == pend_q);                                                  // R7
endmodule

bind banked_irq_mask_ctrl birq_checker #(
    .N_WORDS (N_WORDS),
    .N_BANKS (N_BANKS),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl   (src_lvl),
    .bus_wr    (bus_wr),
    .bus_bank  (bus_bank),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_req   (irq_req),
    .mask_all  (mask_all)
);

// File: tb/banked_irq_mask_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed corner tests.
module banked_irq_mask_ctrl_tb_top;
    localparam int NW = 2;
    localparam int NB = 2;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   src_lvl = '0;
    logic          bus_wr = 1'b0;
    logic [0:0]    bus_bank = '0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NB-1:0] irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    banked_irq_mask_ctrl #(.N_WORDS(NW), .N_BANKS(NB), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr(bus_wr),
        .bus_bank(bus_bank), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    // Byte offset from R2: (kind * NW + word) * 4.
    function automatic logic [AW-1:0] offs(int kind, int word);
        return AW'((kind * NW + word) * 4);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int bank, logic [AW-1:0] a, logic [31:0] d);
        bus_bank = 1'(bank); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int bank, logic [AW-1:0] a, output logic [31:0] d);
        bus_bank = 1'(bank); bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic mask_all_banks();
        for (int b = 0; b < NB; b++)
            for (int w = 0; w < NW; w++) wr(b, offs(2, w), 32'hFFFF_FFFF);
    endtask

    // {bank, word, clear data, source word, expected irq_req}
    localparam logic [67:0] VEC [6] = '{
        {1'b0, 1'b0, 32'h0000_0001, 32'h0000_0001, 2'b01},
        {1'b0, 1'b0, 32'h0000_0002, 32'h0000_0001, 2'b00},
        {1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000, 2'b10},
        {1'b1, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF, 2'b00},
        {1'b0, 1'b1, 32'h0000_00F0, 32'h0000_0010, 2'b01},
        {1'b1, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 2'b00}
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports.
        chk("R1 irq", 32'(irq_req), 32'd0);
        for (int b = 0; b < NB; b++)
            for (int w = 0; w < NW; w++) begin
                rd(b, offs(1, w), d); chk("R1 mask", d, 32'hFFFF_FFFF);
            end

        // R7 table: one source word live, one clear write, request one clock later.
        foreach (VEC[i]) begin
            mask_all_banks();
            src_lvl = '0;
            src_lvl[32'(VEC[i][66])*32 +: 32] = VEC[i][33:2];
            wr(int'(VEC[i][67]), offs(3, int'(VEC[i][66])), VEC[i][65:34]);
            @(posedge clk); @(negedge clk);
            chk("R7 table", 32'(irq_req), 32'(VEC[i][1:0]));
        end
        mask_all_banks();

        // R3: live level reads, no latching, writes ignored; R2 low bits ignored.
        src_lvl = 64'hA5A5_0000_1234_5678;
        rd(0, offs(0, 0), d); chk("R3 level w0", d, 32'h1234_5678);
        rd(1, offs(0, 1), d); chk("R3 level w1", d, 32'hA5A5_0000);
        rd(0, offs(0, 1) | 8'h3, d); chk("R2 low bits", d, 32'hA5A5_0000);
        wr(0, offs(0, 0), 32'h0);
        rd(0, offs(0, 0), d); chk("R3 write ignored", d, 32'h1234_5678);
        rd(0, offs(1, 0), d); chk("R3 mask kept", d, 32'hFFFF_FFFF);
        src_lvl = '0;
        rd(0, offs(0, 0), d); chk("R3 no latch", d, 32'h0);

        // R6: readback write ignored, set/clear read zero.
        wr(0, offs(1, 0), 32'h0);
        rd(0, offs(1, 0), d); chk("R6 mstat write", d, 32'hFFFF_FFFF);
        rd(0, offs(2, 0), d); chk("R6 set reads 0", d, 32'h0);
        rd(0, offs(3, 1), d); chk("R6 clr reads 0", d, 32'h0);

        // R5 / R4: partial clear then partial set.
        wr(0, offs(3, 0), 32'h0000_00FF);
        rd(0, offs(1, 0), d); chk("R5 clear", d, 32'hFFFF_FF00);
        wr(0, offs(2, 0), 32'h0000_000F);
        rd(0, offs(1, 0), d); chk("R4 set", d, 32'hFFFF_FF0F);

        // R8: other bank untouched.
        rd(1, offs(1, 0), d); chk("R8 bank1", d, 32'hFFFF_FFFF);

        // R9: out-of-range offsets.
        wr(0, 8'h20, 32'hFFFF_FFFF);
        wr(0, 8'h38, 32'hFFFF_FFFF);
        rd(0, offs(1, 0), d); chk("R9 write ignored", d, 32'hFFFF_FF0F);
        rd(0, 8'h20, d); chk("R9 read 0x20", d, 32'h0);
        rd(0, 8'hFC, d); chk("R9 read 0xFC", d, 32'h0);

        // R7: timing of rise and fall; bit 4 of word0 is unmasked in bank0.
        src_lvl[4] = 1'b1;
        #1 chk("R7 not yet", 32'(irq_req), 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R7 rise", 32'(irq_req), 32'd1);
        src_lvl[4] = 1'b0;
        #1 chk("R7 still high", 32'(irq_req), 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R7 fall", 32'(irq_req), 32'd0);
        src_lvl[8] = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 masked bit", 32'(irq_req), 32'd0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule